// File: doc/BRIEF.md
# Half-integer clock divider branch

This block is one branch of a clock tree. A source mux picks one of several incoming clocks. An enable gate follows the mux, and a divider after the gate divides the clock by the half-integer ratio (2N+3)/2, which gives 1.5, 2.5, 3.5 and so on. N is an unsigned field in a 32-bit control register. The mux select sits in the same register. The gate enable is a single bit in a second register. Software picks N and the source; the block applies them.

The divider works on both edges of the selected clock. A rising-edge state machine has two states. `S_HALT` is the state while reset is held or the gate is off. `S_RUN` is the counting state. `S_HALT` moves to `S_RUN` on the first rising edge after the gate's reset has been released, and the only way back is the asynchronous reset. In `S_RUN` a phase counter tracks the position of the rising-edge half inside an output period of 2N+3 half-periods. A falling-edge register derives the next half from that position. The two registers each hold a toggle bit, and the output is the XOR of the two bits, so only one input to the XOR changes at any instant.

Both registers are written from a simple synchronous bus. With the default masked-write mode, the upper 16 bits of a written word act as a per-bit write enable for the lower 16 bits, so one field can change without a read-modify-write. The plain mode instead replaces only the defined fields.

Top module: `hdiv_branch`

## Requirements
- R1: The output period is exactly 2N+3 half-periods of the selected source, so f_out = 2*f_in/(2N+3). With N=0 the ratio is 1.5, and each step of N adds 1.0 to it.
- R2: Within each output period the output is high for N+2 half-periods and then low for N+1 half-periods.
- R3: N is read from control bits [DIV_LSB+DIV_W-1:DIV_LSB], which are bits [3:0] by default. The largest N, 2^DIV_W-1 (15 by default), divides by (2*15+3)/2 = 16.5.
- R4: In masked mode a write changes bit k (k<16) of the addressed register only when bit k+16 of the written word is 1. The upper 16 bits of each register always read 0. Address 0 selects the control register and address 1 selects the gate register.
- R5: In plain mode a write to the control register replaces only the divider field and the select field, and a write to the gate register replaces only the enable bit. All other bits keep their value, and that value is 0 after reset.
- R6: With more than one source, the control bits [SEL_LSB+SEL_W-1:SEL_LSB] (bit 8 by default) give the index of the source that feeds the gate and the divider.
- R7: While gate bit GATE_BIT (bit 0 of address 1) is 0, the output is held low and the divider is held in `S_HALT`. After the bit is set, the first output edge is rising and it opens a full high phase of N+2 half-periods.
- R8: A new N is loaded only at a rising source edge where a new output period begins. Every high or low phase that is produced is either complete for the old N or complete for the new N.
- R9: After reset both registers read 0 and the output is low.
- R10: Without a bus write (wr_en low), neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for the register writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NUM_SRC | Candidate source clocks |
| wr_en | input | 1 | Write strobe, sampled on clk |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the gate register |
| wr_data | input | 32 | Write word; in masked mode the upper half is the enable mask |
| clk_out | output | 1 | Divided clock |
| ctrl_q | output | 32 | Control register readback |
| gate_q | output | 32 | Gate register readback |

## Verification
The properties assume that the source clocks run freely, that rst_n is low at time zero, and that the select field changes only while the gate is off, because switching the mux while it is live is outside this block. The register properties assume that writes are synchronous to clk. The stimulus meets these assumptions: it sets the gate bit to 0 before every change of source or large change of N. It makes one change of N while the output is running, which exercises R8, and for that case the bench accepts a load in either of the two candidate periods. The source clock periods are not multiples of the bus clock, so bus edges and source edges rarely fall at the same instant.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_GATE = 1'b1;

    typedef enum logic {
        S_HALT = 1'b0,
        S_RUN  = 1'b1
    } hdiv_state_e;

    // upper half of the word enables the matching lower bit; upper half stored as zero
    function automatic logic [REG_W-1:0] merge_masked(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] wd
    );
        logic [HALF_W-1:0] en;
        en = wd[REG_W-1:HALF_W];
        return {{HALF_W{1'b0}}, (old_v[HALF_W-1:0] & ~en) | (wd[HALF_W-1:0] & en)};
    endfunction

    // only the bits listed in fld take the written value
    function automatic logic [REG_W-1:0] merge_fields(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] wd,
        input logic [REG_W-1:0] fld
    );
        return (old_v & ~fld) | (wd & fld);
    endfunction

endpackage

// File: rtl/hdiv_regs.sv
`timescale 1ns/1ps
module hdiv_regs
    import hdiv_pkg::*;
#(
    parameter bit          MASKED_WR = 1'b1,
    parameter logic [31:0] CTRL_F    = 32'h0000_010F,
    parameter logic [31:0] GATE_F    = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  ctrl_q,
    output logic [REG_W-1:0]  gate_q
);

    logic [REG_W-1:0] ctrl_m, ctrl_p, gate_m, gate_p;
    logic [REG_W-1:0] ctrl_d, gate_d;

    always_comb begin
        ctrl_m = merge_masked(ctrl_q, wr_data);
        gate_m = merge_masked(gate_q, wr_data);
        ctrl_p = merge_fields(ctrl_q, wr_data, CTRL_F);
        gate_p = merge_fields(gate_q, wr_data, GATE_F);
        ctrl_d = MASKED_WR ? ctrl_m : ctrl_p;
        gate_d = MASKED_WR ? gate_m : gate_p;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            gate_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= ctrl_d;
            else                      gate_q <= gate_d;
        end
    end

endmodule

// File: rtl/hdiv_rstsync.sv
`timescale 1ns/1ps
module hdiv_rstsync (
    input  logic clk_i,
    input  logic arst_n,
    output logic srst_n
);

    logic [1:0] chain_q;

    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) chain_q <= 2'b00;
        else         chain_q <= {chain_q[0], 1'b1};
    end

    assign srst_n = chain_q[1];

endmodule

// File: rtl/hdiv_core.sv
`timescale 1ns/1ps
module hdiv_core
    import hdiv_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic               clk_i,
    input  logic               arst_n,
    input  logic [DIV_W-1:0]   n_req,
    output logic               clk_o,
    output logic [DIV_W+1:0]   phase_o,
    output logic [DIV_W-1:0]   nact_o
);

    localparam int PW  = DIV_W + 2;
    localparam int PW1 = PW + 1;

    hdiv_state_e      state_q;
    logic [PW-1:0]    phase_q;
    logic [DIV_W-1:0] n_act;
    logic             tog_p, tog_n;

    logic [PW-1:0]    period_len, high_len;
    logic [PW:0]      sum_p;
    logic [PW-1:0]    phase_nxt, half_raw, phase_hn;
    logic             want_p, want_n;

    // half-period bookkeeping for the next rising half and the next falling half
    always_comb begin
        period_len = {1'b0, n_act, 1'b0} + PW'(3);
        high_len   = {2'b00, n_act} + PW'(2);
        sum_p      = {1'b0, phase_q} + PW1'(2);
        if (sum_p >= {1'b0, period_len}) phase_nxt = PW'(sum_p - {1'b0, period_len});
        else                             phase_nxt = PW'(sum_p);
        want_p     = phase_nxt < high_len;
        half_raw   = phase_q + PW'(1);
        phase_hn   = (half_raw == period_len) ? '0 : half_raw;
        want_n     = phase_hn < high_len;
    end

    // state register, phase counter and ratio load
    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= S_HALT;
            phase_q <= '0;
            n_act   <= '0;
        end else begin
            unique case (state_q)
                S_HALT: begin
                    state_q <= S_RUN;
                    phase_q <= '0;
                    n_act   <= n_req;
                end
                S_RUN: begin
                    phase_q <= phase_nxt;
                    if (phase_nxt == '0) n_act <= n_req;
                end
            endcase
        end
    end

    // rising-edge output toggle
    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            tog_p <= 1'b0;
        end else begin
            unique case (state_q)
                S_HALT: tog_p <= ~tog_n;
                S_RUN:  tog_p <= want_p ^ tog_n;
            endcase
        end
    end

    // falling-edge output toggle
    always_ff @(negedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            tog_n <= 1'b0;
        end else begin
            unique case (state_q)
                S_HALT: tog_n <= tog_p;
                S_RUN:  tog_n <= want_n ^ tog_p;
            endcase
        end
    end

    assign clk_o   = tog_p ^ tog_n;
    assign phase_o = phase_q;
    assign nact_o  = n_act;

endmodule

// File: rtl/hdiv_branch.sv
`timescale 1ns/1ps
module hdiv_branch
    import hdiv_pkg::*;
#(
    parameter int NUM_SRC   = 2,
    parameter int DIV_W     = 4,
    parameter int DIV_LSB   = 0,
    parameter int SEL_LSB   = 8,
    parameter int GATE_BIT  = 0,
    parameter bit MASKED_WR = 1'b1,
    parameter bit HAS_GATE  = 1'b1,
    parameter bit HAS_DIV   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [31:0]        wr_data,
    output logic               clk_out,
    output logic [31:0]        ctrl_q,
    output logic [31:0]        gate_q
);

    localparam int          SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int          PW          = DIV_W + 2;
    localparam logic [31:0] DIV_F       = ((32'd1 << DIV_W) - 32'd1) << DIV_LSB;
    localparam logic [31:0] SEL_F       = (NUM_SRC > 1) ? (((32'd1 << SEL_W) - 32'd1) << SEL_LSB) : 32'd0;
    localparam logic [31:0] CTRL_FIELDS = DIV_F | SEL_F;
    localparam logic [31:0] GATE_FIELDS = 32'd1 << GATE_BIT;

    logic             sel_clk;
    logic             gate_en;
    logic             core_rst_n;
    logic [DIV_W-1:0] n_req;
    logic [PW-1:0]    phase_mon;
    logic [DIV_W-1:0] nact_mon;

    hdiv_regs #(
        .MASKED_WR (MASKED_WR),
        .CTRL_F    (CTRL_FIELDS),
        .GATE_F    (GATE_FIELDS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .gate_q  (gate_q)
    );

    assign n_req = ctrl_q[DIV_LSB +: DIV_W];

    if (NUM_SRC > 1) begin : g_mux
        logic [SEL_W-1:0] sel;
        assign sel     = ctrl_q[SEL_LSB +: SEL_W];
        assign sel_clk = (32'(sel) < NUM_SRC) ? src_clk[sel] : src_clk[0];
    end else begin : g_nomux
        assign sel_clk = src_clk[0];
    end

    if (HAS_GATE) begin : g_gate
        assign gate_en = gate_q[GATE_BIT];
    end else begin : g_nogate
        assign gate_en = 1'b1;
    end

    if (HAS_DIV) begin : g_div
        hdiv_rstsync u_sync (
            .clk_i  (sel_clk),
            .arst_n (rst_n & gate_en),
            .srst_n (core_rst_n)
        );
        hdiv_core #(
            .DIV_W (DIV_W)
        ) u_core (
            .clk_i   (sel_clk),
            .arst_n  (core_rst_n),
            .n_req   (n_req),
            .clk_o   (clk_out),
            .phase_o (phase_mon),
            .nact_o  (nact_mon)
        );
    end else begin : g_nodiv
        assign core_rst_n = rst_n & gate_en;
        assign clk_out    = sel_clk & gate_en;
        assign phase_mon  = '0;
        assign nact_mon   = '0;
    end

endmodule

// File: rtl/hdiv_branch_chk.sv
`timescale 1ns/1ps
module hdiv_branch_chk #(
    parameter bit          MASKED_WR = 1'b1,
    parameter int          DIV_W     = 4,
    parameter logic [31:0] CTRL_F    = 32'h0000_010F,
    parameter logic [31:0] GATE_F    = 32'h0000_0001
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [31:0]      wr_data,
    input logic [31:0]      ctrl_q,
    input logic [31:0]      gate_q,
    input logic             sel_clk,
    input logic             core_rst_n,
    input logic             clk_out,
    input logic [DIV_W+1:0] phase_mon,
    input logic [DIV_W-1:0] nact_mon
);

    logic [DIV_W+1:0] period_lim;
    assign period_lim = {1'b0, nact_mon, 1'b0} + (DIV_W+2)'(3);

    // R4: unmasked lower bits of the control word survive a masked write
    a_r4_mask_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (MASKED_WR && wr_en && wr_addr == 1'b0)
        |=> (((ctrl_q ^ $past(ctrl_q)) & ~{16'h0000, $past(wr_data[31:16])}) == 32'h0));

    // R4: same for the gate word
    a_r4_mask_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (MASKED_WR && wr_en && wr_addr == 1'b1)
        |=> (((gate_q ^ $past(gate_q)) & ~{16'h0000, $past(wr_data[31:16])}) == 32'h0));

    // R4: upper halves read zero in masked mode
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        MASKED_WR |-> (ctrl_q[31:16] == 16'h0 && gate_q[31:16] == 16'h0));

    // R5: plain-mode write touches only the declared fields
    a_r5_plain_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (!MASKED_WR && wr_en)
        |=> (((ctrl_q ^ $past(ctrl_q)) & ~CTRL_F) == 32'h0 &&
             ((gate_q ^ $past(gate_q)) & ~GATE_F) == 32'h0));

    // R10: no write, no change
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ctrl_q) && $stable(gate_q)));

    // R7: output held low while the divider is held off
    a_r7_gate_low: assert property (@(negedge sel_clk) disable iff (!rst_n)
        !core_rst_n |-> !clk_out);

    // R1: phase position always inside the current period
    a_r1_phase_range: assert property (@(posedge sel_clk) disable iff (!core_rst_n)
        phase_mon < period_lim);

    // R8: the active ratio changes only at the start of a period
    a_r8_load_at_start: assert property (@(posedge sel_clk) disable iff (!core_rst_n)
        !$stable(nact_mon) |-> (phase_mon == '0));

endmodule

bind hdiv_branch hdiv_branch_chk #(
    .MASKED_WR (MASKED_WR),
    .DIV_W     (DIV_W),
    .CTRL_F    (CTRL_FIELDS),
    .GATE_F    (GATE_FIELDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl_q     (ctrl_q),
    .gate_q     (gate_q),
    .sel_clk    (sel_clk),
    .core_rst_n (core_rst_n),
    .clk_out    (clk_out),
    .phase_mon  (phase_mon),
    .nact_mon   (nact_mon)
);

// File: tb/hdiv_branch_tb.sv
`timescale 1ns/1ps
module hdiv_branch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src0 = 1'b0;
    logic        src1 = 1'b0;
    logic        wr_en_m = 1'b0;
    logic        wr_en_p = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic        out_m, out_p;
    logic [31:0] ctrl_m, gate_m, ctrl_p, gate_p;

    logic mon_which = 1'b0;
    logic mon_sel   = 1'b0;
    logic obs, src_obs;
    assign obs     = mon_which ? out_p : out_m;
    assign src_obs = mon_sel ? src1 : src0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;
    initial begin #0.2; forever #5.3 src0 = ~src0; end
    initial begin #0.9; forever #7.1 src1 = ~src1; end

    hdiv_branch u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk ({src1, src0}),
        .wr_en   (wr_en_m),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_out (out_m),
        .ctrl_q  (ctrl_m),
        .gate_q  (gate_m)
    );

    hdiv_branch #(.NUM_SRC(1), .MASKED_WR(1'b0)) u_dut_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src0),
        .wr_en   (wr_en_p),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clk_out (out_p),
        .ctrl_q  (ctrl_p),
        .gate_q  (gate_p)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input bit which, input logic addr, input logic [31:0] data);
        @(negedge clk);
        wr_addr = addr;
        wr_data = data;
        if (which) wr_en_p = 1'b1; else wr_en_m = 1'b1;
        @(negedge clk);
        wr_en_m = 1'b0;
        wr_en_p = 1'b0;
    endtask

    // output must stay low for the whole window
    task automatic hold_low(input bit which, input string req);
        int highs;
        highs = 0;
        mon_which = which;
        for (int i = 0; i < 150; i++) begin
            #1;
            if (obs !== 1'b0) highs++;
        end
        check(highs == 0, req, "output high samples while gated", highs, 0);
    endtask

    // behavioural reference: half index j from the first rising output edge
    task automatic model_run(input bit which, input bit sel, input int n,
                             input int halves, input string req);
        int m, bad, first_bad;
        logic exp_v;
        m = 2 * n + 3;
        bad = 0;
        first_bad = -1;
        mon_which = which;
        mon_sel   = sel;
        #0.05;
        @(posedge obs);
        #1;
        for (int j = 0; j < halves; j++) begin
            if (j != 0) begin
                @(src_obs);
                #1;
            end
            exp_v = ((j % m) < n + 2);
            if (obs !== exp_v) begin
                bad++;
                if (first_bad < 0) first_bad = j;
            end
        end
        check(bad == 0, req, $sformatf("N=%0d waveform mismatches (first at half %0d)", n, first_bad), bad, 0);
    endtask

    // measure phase lengths while N changes from n_old to n_new mid-run
    task automatic phase_scan(input bit sel, input int n_old, input int n_new, input int halves);
        int run, bad, last_hi, last_lo, hi_old, hi_new;
        logic level;
        mon_which = 1'b0;
        mon_sel   = sel;
        bad = 0; last_hi = 0; last_lo = 0; hi_old = 0; hi_new = 0;
        #0.05;
        @(posedge obs);
        #1;
        level = 1'b1;
        run = 1;
        for (int j = 1; j < halves; j++) begin
            @(src_obs);
            #1;
            if (obs === level) begin
                run++;
            end else begin
                if (level) begin
                    if (run == n_old + 2) hi_old++;
                    else if (run == n_new + 2) hi_new++;
                    else bad++;
                    last_hi = run;
                end else begin
                    if (run != n_old + 1 && run != n_new + 1) bad++;
                    last_lo = run;
                end
                level = obs;
                run = 1;
            end
        end
        check(bad == 0, "R8", "phases of neither old nor new length", bad, 0);
        check(hi_old > 0 && hi_new > 0, "R8", "old then new high phases seen", hi_new, 1);
        check(last_hi == n_new + 2 && last_lo == n_new + 1, "R8", "final high phase length", last_hi, n_new + 2);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9: reset state
        check(ctrl_m == 32'h0, "R9", "ctrl after reset", ctrl_m, 0);
        check(gate_m == 32'h0, "R9", "gate after reset", gate_m, 0);
        check(out_m == 1'b0, "R9", "output after reset", out_m, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ctrl_m == 32'h0 && gate_m == 32'h0, "R10", "regs idle without writes", ctrl_m, 0);

        // R4/R6: set N=2 and source 1 with one masked write
        bus_write(1'b0, 1'b0, 32'h010F_0102);
        check(ctrl_m == 32'h0000_0102, "R4", "ctrl after masked write", ctrl_m, 32'h102);
        hold_low(1'b0, "R7");

        bus_write(1'b0, 1'b1, 32'h0001_0001);
        check(gate_m == 32'h0000_0001, "R4", "gate after masked write", gate_m, 1);
        model_run(1'b0, 1'b1, 2, 80, "R1 R2 R6 R7");

        // R8: live ratio change 2 -> 4 (mask covers only the divider bits)
        fork
            phase_scan(1'b1, 2, 4, 240);
            begin
                #300;
                bus_write(1'b0, 1'b0, 32'h000F_0004);
            end
        join
        check(ctrl_m == 32'h0000_0104, "R4", "select kept by divider-only mask", ctrl_m, 32'h104);

        // R7: gate off holds low
        bus_write(1'b0, 1'b1, 32'h0001_0000);
        hold_low(1'b0, "R7");

        // R4: zero mask changes nothing
        bus_write(1'b0, 1'b0, 32'h0000_FFFF);
        check(ctrl_m == 32'h0000_0104, "R4", "zero-mask write ignored", ctrl_m, 32'h104);
        // R6: back to source 0
        bus_write(1'b0, 1'b0, 32'h0100_0000);
        check(ctrl_m == 32'h0000_0004, "R6", "select cleared", ctrl_m, 4);
        bus_write(1'b0, 1'b1, 32'h0001_0001);
        model_run(1'b0, 1'b0, 4, 90, "R1 R6");

        // R1/R2: smallest ratio
        bus_write(1'b0, 1'b1, 32'h0001_0000);
        bus_write(1'b0, 1'b0, 32'h000F_0000);
        bus_write(1'b0, 1'b1, 32'h0001_0001);
        model_run(1'b0, 1'b0, 0, 60, "R1 R2");

        // R3: largest ratio
        bus_write(1'b0, 1'b1, 32'h0001_0000);
        bus_write(1'b0, 1'b0, 32'h000F_000F);
        check(ctrl_m == 32'h0000_000F, "R3", "largest N stored", ctrl_m, 15);
        bus_write(1'b0, 1'b1, 32'h0001_0001);
        model_run(1'b0, 1'b0, 15, 140, "R3 R1");

        // R5: plain-mode instance
        bus_write(1'b1, 1'b0, 32'hFFFF_FFF7);
        check(ctrl_p == 32'h0000_0007, "R5", "plain ctrl keeps non-field bits", ctrl_p, 7);
        bus_write(1'b1, 1'b1, 32'hFFFF_FFFF);
        check(gate_p == 32'h0000_0001, "R5", "plain gate keeps non-field bits", gate_p, 1);
        model_run(1'b1, 1'b0, 7, 80, "R5 R1");
        bus_write(1'b1, 1'b1, 32'h0000_0000);
        hold_low(1'b1, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule